// File: doc/BRIEF.md
# Sync Word Frame Aligner

This block finds superframe boundaries in a serial bit stream. One bit arrives with each `bit_valid` strobe, and each superframe opens with a fixed 24-bit synchronization word. Payload data can reproduce that word by chance, so one match is only a candidate alignment. After a match, the block counts bits to the place where the next word should end and checks it there. Lock is declared only after a set number of such checks in a row succeed.

Once locked, the block marks every confirmed boundary with a one-cycle pulse and reports the position of the next bit within the superframe. It stays locked through isolated corruption of the sync word. It goes back to searching only after a set number of consecutive predicted boundaries fail. The superframe length, the number of confirmations and the tolerated miss count are parameters.

Top module: `sync_aligner`

## Requirements
- R1: After reset, `locked` is 0, `sf_start` is 0 and `bit_index` is 0.
- R2: The sync word is 0xD21DB8. A match occurs on the accepted bit that completes it, where the earliest of the 24 most recently accepted bits is compared with bit 23 (MSB first). The same word sent LSB first does not match.
- R3: A match found while searching opens a candidate alignment and does not raise `locked`. `locked` rises only after CONFIRM_N further matches, each at a predicted boundary exactly SF_LEN accepted bits after the previous one.
- R4: While confirming, a predicted boundary without a match drops the candidate. The block returns to searching, and `bit_index` stays 0 until the next match.
- R5: While confirming or locked, a match at any position other than the predicted boundary is ignored. It does not move `bit_index` and does not produce `sf_start`.
- R6: While locked, the block leaves lock only after MISS_N consecutive predicted boundaries without a match. A matching boundary clears the miss count.
- R7: `sf_start` is high for exactly one cycle, in the cycle after a matching predicted boundary bit is accepted. In that cycle `locked` is 1 and `bit_index` is 0. It never asserts outside lock.
- R8: While aligned (confirming or locked), `bit_index` is the position of the next bit to be accepted. Position 0 is the first bit after the sync word, so the sync word occupies positions SF_LEN-24 to SF_LEN-1. It increments once per accepted bit, wraps from SF_LEN-1 to 0 and holds while `bit_valid` is low. While searching it is 0.
- R9: `bit_in` is ignored in cycles where `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial data bit |
| locked | output | 1 | Alignment confirmed |
| sf_start | output | 1 | One-cycle pulse at each confirmed superframe boundary |
| bit_index | output | $clog2(SF_LEN) | Position of the next bit within the superframe |

## Verification
The bench drives the word in both bit orders, which separates a correct MSB-first comparison from a reversed one. Streams carry zero payload, payload that itself contains the sync word, and boundaries where the word is replaced by zeros. These show whether the aligner acts only at predicted positions and whether it counts confirmations and misses correctly. The index is swept bit by bit across a full superframe and its wrap, with noisy `bit_in` during idle cycles. This tells apart a counter that advances on strobes from one that advances on clocks or on data.

// File: rtl/sync_align_pkg.sv
package sync_align_pkg;
   typedef enum logic [1:0] {
      ST_SEARCH  = 2'd0,
      ST_CONFIRM = 2'd1,
      ST_LOCKED  = 2'd2
   } align_state_t;
endpackage

// File: rtl/sync_pattern_match.sv
module sync_pattern_match #(
   parameter int                 PAT_W   = 24,
   parameter logic [PAT_W-1:0]   PATTERN = 24'hD21DB8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   output logic hit
);
   logic [PAT_W-2:0] hist_q;
   logic [PAT_W-1:0] window;

   // newest bit lands in the LSB, so the oldest bit meets the pattern MSB (R2)
   assign window = {hist_q, bit_in};
   assign hit    = bit_valid && (window == PATTERN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hist_q <= '0;
      else if (bit_valid) hist_q <= window[PAT_W-2:0];
   end

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> $stable(hist_q));
endmodule

// File: rtl/sync_pos_counter.sv
module sync_pos_counter #(
   parameter int SF_LEN = 192,
   parameter int IDX_W  = $clog2(SF_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             clear,
   output logic [IDX_W-1:0] idx,
   output logic             at_boundary
);
   logic [IDX_W-1:0] idx_q, idx_nxt;

   generate
      if (SF_LEN == (1 << IDX_W)) begin : g_pow2
         assign at_boundary = &idx_q;
         assign idx_nxt     = idx_q + IDX_W'(1);
      end else begin : g_cmp
         assign at_boundary = (idx_q == IDX_W'(SF_LEN - 1));
         assign idx_nxt     = at_boundary ? '0 : idx_q + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         idx_q <= '0;
      else if (clear)     idx_q <= '0;
      else if (bit_valid) idx_q <= idx_nxt;
   end

   assign idx = idx_q;

   a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < IDX_W'(SF_LEN - 1) || idx_q == IDX_W'(SF_LEN - 1));
   a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !clear) |=> $stable(idx_q));
endmodule

// File: rtl/sync_align_fsm.sv
module sync_align_fsm
   import sync_align_pkg::*;
#(
   parameter int CONFIRM_N = 3,
   parameter int MISS_N    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic hit,
   input  logic at_boundary,
   output logic searching,
   output logic locked,
   output logic sf_start
);
   localparam int CONF_W = $clog2(CONFIRM_N + 1);
   localparam int MISS_W = $clog2(MISS_N + 1);

   align_state_t      state_q, state_d;
   logic [CONF_W-1:0] conf_q, conf_d;
   logic [MISS_W-1:0] miss_q, miss_d;
   logic              pulse_d, pulse_q, check;

   assign check = bit_valid && at_boundary;

   always_comb begin
      state_d = state_q;
      conf_d  = conf_q;
      miss_d  = miss_q;
      pulse_d = 1'b0;
      unique case (state_q)
         ST_SEARCH: begin
            if (hit) begin
               state_d = ST_CONFIRM;
               conf_d  = '0;
            end
         end
         ST_CONFIRM: begin
            if (check) begin
               if (!hit) begin
                  state_d = ST_SEARCH;
               end else if (conf_q == CONF_W'(CONFIRM_N - 1)) begin
                  state_d = ST_LOCKED;
                  miss_d  = '0;
                  pulse_d = 1'b1;
               end else begin
                  conf_d = conf_q + CONF_W'(1);
               end
            end
         end
         ST_LOCKED: begin
            if (check) begin
               if (hit) begin
                  miss_d  = '0;
                  pulse_d = 1'b1;
               end else if (miss_q == MISS_W'(MISS_N - 1)) begin
                  state_d = ST_SEARCH;
               end else begin
                  miss_d = miss_q + MISS_W'(1);
               end
            end
         end
         default: state_d = ST_SEARCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SEARCH;
         conf_q  <= '0;
         miss_q  <= '0;
         pulse_q <= 1'b0;
      end else begin
         state_q <= state_d;
         conf_q  <= conf_d;
         miss_q  <= miss_d;
         pulse_q <= pulse_d;
      end
   end

   assign searching = (state_q == ST_SEARCH);
   assign locked    = (state_q == ST_LOCKED);
   assign sf_start  = pulse_q;

   a_r7_pulse_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
      sf_start |-> locked);
   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      sf_start |=> !sf_start);
   a_r3_lock_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(hit && at_boundary && bit_valid));
   a_r6_unlock_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(bit_valid && at_boundary && !hit));
endmodule

// File: rtl/sync_aligner.sv
module sync_aligner #(
   parameter int               PAT_W     = 24,
   parameter logic [PAT_W-1:0] PATTERN   = 24'hD21DB8,
   parameter int               SF_LEN    = 192,
   parameter int               CONFIRM_N = 3,
   parameter int               MISS_N    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bit_valid,
   input  logic                      bit_in,
   output logic                      locked,
   output logic                      sf_start,
   output logic [$clog2(SF_LEN)-1:0] bit_index
);
   localparam int IDX_W = $clog2(SF_LEN);

   generate
      if (PAT_W < 2) begin : g_bad_pat
         $error("sync_aligner: PAT_W must be at least 2");
      end
      if (SF_LEN <= PAT_W) begin : g_bad_len
         $error("sync_aligner: SF_LEN must exceed PAT_W");
      end
      if (CONFIRM_N < 1 || MISS_N < 1) begin : g_bad_cnt
         $error("sync_aligner: CONFIRM_N and MISS_N must be at least 1");
      end
   endgenerate

   logic hit, at_boundary, searching;

   sync_pattern_match #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .hit       (hit)
   );

   sync_pos_counter #(.SF_LEN(SF_LEN), .IDX_W(IDX_W)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_valid   (bit_valid),
      .clear       (searching),
      .idx         (bit_index),
      .at_boundary (at_boundary)
   );

   sync_align_fsm #(.CONFIRM_N(CONFIRM_N), .MISS_N(MISS_N)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_valid   (bit_valid),
      .hit         (hit),
      .at_boundary (at_boundary),
      .searching   (searching),
      .locked      (locked),
      .sf_start    (sf_start)
   );
endmodule

// File: tb/sync_aligner_bench.sv
module sync_aligner_bench;
   localparam int          CLK_PERIOD = 10;
   localparam int          SF         = 48;
   localparam int          CN         = 2;
   localparam int          MN         = 2;
   localparam logic [23:0] PAT        = 24'hD21DB8;
   localparam int          PL         = SF - 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic       locked, sf_start;
   logic [5:0] bit_index;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_aligner #(.SF_LEN(SF), .CONFIRM_N(CN), .MISS_N(MN)) u_sync_aligner (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .locked(locked), .sf_start(sf_start), .bit_index(bit_index)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one accepted bit; afterwards idle with inverted data (R9 noise)
   task automatic send(input logic b);
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = b;
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = ~b;
   endtask

   task automatic send_pat();
      for (int i = 23; i >= 0; i--) send(PAT[i]);
   endtask

   task automatic send_zeros(input int n);
      for (int i = 0; i < n; i++) send(1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bit_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int exp_idx;
      // R1 reset state
      repeat (2) @(negedge clk);
      chk("R1", "locked in reset", locked, 0);
      chk("R1", "sf_start in reset", sf_start, 0);
      chk("R1", "bit_index in reset", bit_index, 0);
      do_reset();
      chk("R1", "locked after reset", locked, 0);

      // R2: LSB-first word must not match
      for (int i = 0; i < 24; i++) send(PAT[i]);
      send(1'b0);
      chk("R2", "index after reversed word", bit_index, 0);

      // R2/R3: MSB-first word opens candidate only
      do_reset();
      send_pat();
      chk("R3", "locked after single match", locked, 0);
      send(1'b0);
      chk("R2", "index after word plus one bit", bit_index, 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         bit_in = i[0];
      end
      chk("R9", "index after idle noise", bit_index, 1);
      exp_idx = 1;
      for (int i = 0; i < PL - 1; i++) begin
         send(1'b0);
         exp_idx++;
         chk("R8", "index sweep payload", bit_index, exp_idx);
      end
      for (int i = 23; i >= 0; i--) begin
         send(PAT[i]);
         exp_idx = (exp_idx + 1) % SF;
         chk("R8", "index sweep sync word", bit_index, exp_idx);
      end
      chk("R3", "locked after one confirmation", locked, 0);
      chk("R7", "no pulse before lock", sf_start, 0);
      send_zeros(PL);
      send_pat();
      chk("R3", "locked after CONFIRM_N confirmations", locked, 1);
      chk("R7", "pulse at lock boundary", sf_start, 1);
      chk("R7", "index at pulse", bit_index, 0);
      @(negedge clk);
      chk("R7", "pulse lasts one cycle", sf_start, 0);

      // R5: word inside payload while locked
      send_pat();
      chk("R5", "index after payload copy of word", bit_index, 24);
      chk("R5", "no pulse on payload copy", sf_start, 0);
      chk("R5", "still locked", locked, 1);
      send_pat();
      chk("R7", "pulse at next boundary", sf_start, 1);

      // R6: tolerate isolated misses
      send_zeros(PL + 24);
      chk("R6", "locked after one miss", locked, 1);
      chk("R6", "no pulse on miss", sf_start, 0);
      chk("R8", "index wraps on miss", bit_index, 0);
      send_zeros(PL);
      send_pat();
      chk("R6", "pulse after recovery", sf_start, 1);
      send_zeros(PL + 24);
      chk("R6", "locked after miss count cleared", locked, 1);
      send_zeros(PL + 24);
      chk("R6", "unlock after MISS_N misses", locked, 0);
      chk("R6", "index after unlock", bit_index, 0);
      send(1'b0);
      chk("R8", "index held while searching", bit_index, 0);

      // R4: miss during confirmation
      do_reset();
      send_pat();
      send_zeros(PL);
      send_pat();
      send_zeros(PL + 24);
      chk("R4", "locked after confirm miss", locked, 0);
      send(1'b0);
      chk("R4", "searching after confirm miss", bit_index, 0);
      send_pat();
      send(1'b1);
      chk("R4", "reacquire after drop", bit_index, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule